// File: doc/BRIEF.md
# Eight-Channel DAC Command Controller

This block sits behind a serial bus front end and turns each parsed command into register updates for an eight-channel, double-buffered converter. Every channel has a staging register, a live code register that drives the converter, and a power-down flag. The host can stage a new code, move staged codes to the outputs, do both at once, or power a channel down. One address value reaches every channel together.

A command arrives as a 4-bit opcode, a 4-bit channel address and a 16-bit data field, qualified by a valid strobe. Every register change caused by a command happens on the clock edge that samples the strobe. Codes are `RES_BITS` wide (16, 14 or 12). A parameter chooses whether reset loads zero-scale or mid-scale codes. Opcodes and addresses outside the defined set change no state and raise a one-cycle error flag.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: While reset is held and after it is released, every live code and every staging code equals 0, or 2^(RES_BITS-1) when `MID_SCALE_RESET` is 1. Every power-down flag is 0 and `cmd_err` is 0.
- R2: Opcode 4'b0000 loads the data into the staging register of each addressed channel. No live code and no power-down flag changes.
- R3: Opcode 4'b0001 copies each addressed channel's staging register into its live code and clears that channel's power-down flag.
- R4: Opcode 4'b0010 loads the data into the addressed staging registers. On the same edge every channel's live code takes its staging value, which is the new data for addressed channels and the old staging value for the others, and every power-down flag is cleared.
- R5: Opcode 4'b0011 loads the data into both the staging register and the live code of each addressed channel, and clears its power-down flag.
- R6: Opcode 4'b0100 sets the power-down flag of each addressed channel. Its staging and live codes keep their values.
- R7: Opcode 4'b1111 leaves all state unchanged.
- R8: Address values 0 to 7 select channels 0 to 7, one each. Address 4'b1111 selects all channels at once.
- R9: A valid command with an opcode outside {0000, 0001, 0010, 0011, 0100, 1111}, or with an address outside {0..7, 1111}, changes no state. It drives `cmd_err` high for exactly the cycle that follows the edge that sampled it.
- R10: The code is taken left-justified from `cmd_data[15:16-RES_BITS]`. The lower bits have no effect.
- R11: A command's effect appears on the outputs right after the edge that samples `cmd_valid`. With `cmd_valid` low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Qualifies the command fields this cycle |
| cmd_code | input | 4 | Opcode |
| cmd_addr | input | 4 | Channel address, 4'b1111 for all channels |
| cmd_data | input | 16 | Left-justified code field |
| dac_code | output | NUM_CH*RES_BITS | Live codes, channel i at bits [i*RES_BITS +: RES_BITS] |
| pd_flag | output | NUM_CH | Power-down flag per channel |
| cmd_err | output | 1 | One-cycle pulse after a reserved opcode or address |

## Verification
Live codes and power-down flags are direct register outputs, so a wrong update shows on the ports one cycle after the strobe. A staging register is hidden until a later copy opcode (0001 or 0010) moves it to the live code. A corrupted staging value therefore shows up only at that later transfer, which may come many commands after the fault. The stimulus often reads staging contents back through transfers, including the all-channel transfer, so that such faults surface.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
   typedef enum logic [3:0] {
      OP_STAGE      = 4'b0000,
      OP_XFER       = 4'b0001,
      OP_STAGE_XALL = 4'b0010,
      OP_STAGE_XFER = 4'b0011,
      OP_SLEEP      = 4'b0100,
      OP_IDLE       = 4'b1111
   } dac_op_e;

   localparam logic [3:0] ADDR_BCAST = 4'hF;
   localparam int         FIELD_W    = 16;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
   import dac_cmd_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic              valid,
   input  logic [3:0]        op,
   input  logic [3:0]        addr,
   output logic [NUM_CH-1:0] stage_we,
   output logic [NUM_CH-1:0] live_we,
   output logic [NUM_CH-1:0] xfer,
   output logic [NUM_CH-1:0] wake,
   output logic [NUM_CH-1:0] sleep,
   output logic              bad
);
   logic [NUM_CH-1:0] sel;
   logic              op_ok;
   logic              addr_ok;

   always_comb begin
      for (int i = 0; i < NUM_CH; i++)
         sel[i] = (addr == ADDR_BCAST) || (addr == 4'(i));
      addr_ok = (addr == ADDR_BCAST) || (int'(addr) < NUM_CH);
      op_ok   = op inside {OP_STAGE, OP_XFER, OP_STAGE_XALL,
                           OP_STAGE_XFER, OP_SLEEP, OP_IDLE};
   end

   always_comb begin
      stage_we = '0;
      live_we  = '0;
      xfer     = '0;
      wake     = '0;
      sleep    = '0;
      bad      = valid && !(op_ok && addr_ok);
      if (valid && op_ok && addr_ok) begin
         unique case (op)
            OP_STAGE: stage_we = sel;
            OP_XFER: begin
               xfer = sel;
               wake = sel;
            end
            OP_STAGE_XALL: begin
               stage_we = sel;
               live_we  = sel;
               xfer     = ~sel;
               wake     = '1;
            end
            OP_STAGE_XFER: begin
               stage_we = sel;
               live_we  = sel;
               wake     = sel;
            end
            OP_SLEEP: sleep = sel;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
   parameter int          RES_BITS = 16,
   parameter logic [RES_BITS-1:0] RST_CODE = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RES_BITS-1:0] din,
   input  logic                stage_we,
   input  logic                live_we,
   input  logic                xfer,
   input  logic                wake,
   input  logic                sleep,
   output logic [RES_BITS-1:0] live_q,
   output logic                pd_q
);
   logic [RES_BITS-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= RST_CODE;
         live_q  <= RST_CODE;
         pd_q    <= 1'b0;
      end else begin
         if (stage_we) stage_q <= din;
         if (live_we)   live_q <= din;
         else if (xfer) live_q <= stage_q;
         if (sleep)     pd_q <= 1'b1;
         else if (wake) pd_q <= 1'b0;
      end
   end

   // R6: sleeping keeps the stored code
   p_sleep_keeps_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !live_we && !xfer) |=> ($stable(live_q) && pd_q));

   // R3: a wake request ends power-down
   p_wake_clears_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !sleep) |=> !pd_q);
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
   import dac_cmd_pkg::*;
#(
   parameter int NUM_CH          = 8,
   parameter int RES_BITS        = 16,
   parameter bit MID_SCALE_RESET = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic [3:0]                 cmd_code,
   input  logic [3:0]                 cmd_addr,
   input  logic [15:0]                cmd_data,
   output logic [NUM_CH*RES_BITS-1:0] dac_code,
   output logic [NUM_CH-1:0]          pd_flag,
   output logic                       cmd_err
);
   localparam int                  DROP_W   = FIELD_W - RES_BITS;
   localparam logic [RES_BITS-1:0] RST_CODE = MID_SCALE_RESET ?
      (RES_BITS'(1) << (RES_BITS-1)) : '0;

   generate
      if (!(RES_BITS inside {12, 14, 16}))
         $error("RES_BITS must be 12, 14 or 16");
      if (NUM_CH < 1 || NUM_CH > 15)
         $error("NUM_CH must be 1..15");
   endgenerate

   logic [RES_BITS-1:0] code_in;
   logic [NUM_CH-1:0]   stage_we, live_we, xfer, wake, sleep;
   logic                bad;

   assign code_in = cmd_data[FIELD_W-1 -: RES_BITS];

   dac_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
      .valid    (cmd_valid),
      .op       (cmd_code),
      .addr     (cmd_addr),
      .stage_we (stage_we),
      .live_we  (live_we),
      .xfer     (xfer),
      .wake     (wake),
      .sleep    (sleep),
      .bad      (bad)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      dac_chan #(.RES_BITS(RES_BITS), .RST_CODE(RST_CODE)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .din      (code_in),
         .stage_we (stage_we[g]),
         .live_we  (live_we[g]),
         .xfer     (xfer[g]),
         .wake     (wake[g]),
         .sleep    (sleep[g]),
         .live_q   (dac_code[g*RES_BITS +: RES_BITS]),
         .pd_q     (pd_flag[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cmd_err <= 1'b0;
      else        cmd_err <= bad;
   end

   logic unused_low;
   if (DROP_W > 0) begin : g_drop
      assign unused_low = ^cmd_data[DROP_W-1:0];
   end else begin : g_nodrop
      assign unused_low = 1'b0;
   end

   // R9: error pulse only follows a strobed command
   p_err_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> $past(cmd_valid));

   // R9: reserved opcode or address touches no output state
   p_reserved_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (!(cmd_code inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'hF}) ||
                     (cmd_addr != 4'hF && int'(cmd_addr) >= NUM_CH)))
      |=> ($stable(dac_code) && $stable(pd_flag) && cmd_err));

   // R11: no strobe, no output movement
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(dac_code) && $stable(pd_flag) && !cmd_err));
endmodule

// File: tb/dac_cmd_ctrl_tb.sv
module dac_cmd_ctrl_tb;
   localparam int NCH = 8;
   localparam int RB  = 12;
   localparam bit MID = 1'b1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [3:0]       cmd_code = 4'hF;
   logic [3:0]       cmd_addr = 4'h0;
   logic [15:0]      cmd_data = 16'h0;
   logic [NCH*RB-1:0] dac_code;
   logic [NCH-1:0]   pd_flag;
   logic             cmd_err;

   always #2.5 clk = ~clk;

   dac_cmd_ctrl #(.NUM_CH(NCH), .RES_BITS(RB), .MID_SCALE_RESET(MID)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .dac_code(dac_code),
      .pd_flag(pd_flag), .cmd_err(cmd_err));

   // behavioural reference
   int  m_stage [NCH];
   int  m_live  [NCH];
   bit  m_pd    [NCH];
   bit  m_err;
   int  n_chk = 0, n_fail = 0, cycles = 0;
   bit  chk_on = 1'b0;
   string cur_req = "R1";

   function automatic bit hits(int a, int ch);
      return (a == 15) || (a == ch);
   endfunction

   always @(posedge clk) begin
      int rst_val, d;
      bit ok_op, ok_ad;
      rst_val = MID ? (1 << (RB-1)) : 0;
      d = int'(cmd_data) >> (16 - RB);
      ok_op = (cmd_code <= 4) || (cmd_code == 15);
      ok_ad = (cmd_addr < NCH) || (cmd_addr == 15);
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_stage[c] = rst_val; m_live[c] = rst_val; m_pd[c] = 0;
         end
         m_err = 0;
      end else begin
         m_err = cmd_valid && !(ok_op && ok_ad);
         if (cmd_valid && ok_op && ok_ad) begin
            case (cmd_code)
               0: for (int c = 0; c < NCH; c++) if (hits(cmd_addr, c)) m_stage[c] = d;
               1: for (int c = 0; c < NCH; c++) if (hits(cmd_addr, c)) begin
                     m_live[c] = m_stage[c]; m_pd[c] = 0; end
               2: for (int c = 0; c < NCH; c++) begin
                     if (hits(cmd_addr, c)) m_stage[c] = d;
                     m_live[c] = m_stage[c]; m_pd[c] = 0; end
               3: for (int c = 0; c < NCH; c++) if (hits(cmd_addr, c)) begin
                     m_stage[c] = d; m_live[c] = d; m_pd[c] = 0; end
               4: for (int c = 0; c < NCH; c++) if (hits(cmd_addr, c)) m_pd[c] = 1;
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (chk_on) begin
         for (int c = 0; c < NCH; c++) begin
            int act;
            act = int'(dac_code[c*RB +: RB]);
            n_chk++;
            if (act != m_live[c] || pd_flag[c] != m_pd[c]) begin
               n_fail++;
               $display("FAIL %s ch%0d code/pd actual %0h/%0b expected %0h/%0b",
                        cur_req, c, act, pd_flag[c], m_live[c], m_pd[c]);
            end
         end
         n_chk++;
         if (cmd_err != m_err) begin
            n_fail++;
            $display("FAIL %s cmd_err actual %0b expected %0b", cur_req, cmd_err, m_err);
         end
      end
      if (cycles > 20000) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual %0d cycles expected under 20000", cycles);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic send(input logic [3:0] op, input logic [3:0] ad, input logic [15:0] dt);
      @(negedge clk); #1;
      cmd_valid = 1'b1; cmd_code = op; cmd_addr = ad; cmd_data = dt;
      @(negedge clk); #1;
      cmd_valid = 1'b0; cmd_data = ~dt;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(negedge clk); #1; cmd_data = cmd_data + 16'h1357; end
   endtask

   initial begin
      logic [15:0] lf;
      cur_req = "R1";
      repeat (3) @(negedge clk);
      chk_on = 1'b1;                     // R1 checked during reset
      @(negedge clk); #1; rst_n = 1'b1;
      idle(2);
      cur_req = "R2";  send(4'h0, 4'h2, 16'hABCD); idle(1);
      cur_req = "R3";  send(4'h1, 4'h2, 16'h0000); idle(1);
      cur_req = "R10"; send(4'h3, 4'h5, 16'h123F); send(4'h3, 4'h4, 16'h1230);
      cur_req = "R6";  send(4'h4, 4'h5, 16'hFFFF); send(4'h4, 4'hF, 16'h0);
      cur_req = "R5";  send(4'h3, 4'h0, 16'h7777);
      cur_req = "R8";  send(4'h0, 4'hF, 16'h5550); send(4'h1, 4'h7, 16'h0);
      for (int c = 0; c < NCH; c++) send(4'h3, 4'(c), 16'(c * 16'h1111 + 16'h0100));
      send(4'h0, 4'h1, 16'h1110); send(4'h0, 4'h3, 16'h3330);
      cur_req = "R4";  send(4'h2, 4'h6, 16'h6660); send(4'h4, 4'hF, 16'h0);
      send(4'h2, 4'hF, 16'h9990);
      cur_req = "R7";  send(4'hF, 4'h3, 16'hDEAD);
      cur_req = "R9";  send(4'h5, 4'h1, 16'hBEEF); send(4'h0, 4'h8, 16'hBEEF);
      send(4'hF, 4'h9, 16'h0); send(4'h1, 4'hE, 16'h0);
      @(negedge clk); #1; cmd_valid = 1; cmd_code = 4'h6; cmd_addr = 4'h0;
      @(negedge clk); #1; cmd_code = 4'h0; cmd_addr = 4'hA;
      @(negedge clk); #1; cmd_valid = 0;
      cur_req = "R11"; idle(5);
      lf = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         @(negedge clk); #1;
         cmd_valid = lf[0];
         cmd_code  = (lf[3:1] > 3'd4) ? 4'hF : {1'b0, lf[3:1]};
         cmd_addr  = lf[4] ? 4'hF : {1'b0, lf[7:5]};
         if (lf[15:13] == 3'b111) cmd_code = lf[11:8];
         cmd_data  = {lf[7:0], lf[15:8]};
      end
      @(negedge clk); #1; cmd_valid = 0;
      idle(3);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule